// File: doc/BRIEF.md
# Shared-Memory Address Contention Arbiter

This block sits beside a two-port shared memory of 1K locations and watches both access ports. Each port presents an active-low select and an address. On every clock edge the arbiter checks whether both ports are selected and pointing at the same location. When they are, one port is granted the location and the other is told to wait through an active-low busy flag. Clock cycles measure which port arrived first. A port counts as earlier when it was already selected at that same address in the previous cycle. It does not matter whether the other port got there by changing its address or by lowering its select.

Once a winner is chosen, it keeps the location for as long as the contention lasts. When either port leaves the location, by deselecting or by moving its address, the contention ends. The loser's busy flag is then released. If the loser is still waiting when the former winner comes back, the loser has now been there longer and takes the grant. Both ports may arrive in the same cycle. In that case a static tie rule, left by default, picks the winner, so exactly one port is ever held off.

The block carries no data, so it has no valid/ready interface and applies no back-pressure. Busy flags act as plain level signals that the memory ports obey. All outputs are registered and reflect the inputs sampled at the previous rising edge.

Top module: `dpram_contend_arb`

## Requirements
- R1: When either select is high (inactive), or the two addresses differ, at a rising edge, then after that edge both busy flags are high and both grant outputs are 0.
- R2: Contention exists only when both selects are low and the two addresses are equal. The arbiter's response appears on the outputs right after the rising edge that sampled it.
- R3: Both ports are selected and the left port was already at the address in the previous cycle. If the right port moves its address onto that location, the left port wins: busy_r_n goes low and grant_l goes to 1.
- R4: Both ports are selected and the right port was already at the address in the previous cycle. If the left port moves its address onto that location, the right port wins: busy_l_n goes low and grant_r goes to 1.
- R5: With both addresses already equal, the port whose select went low in an earlier cycle wins once the other port's select also goes low.
- R6: When both ports reach a contended location in the same cycle, whether by select or by address, the left port wins (parameter TIE_LEFT=1). Both busy flags are never low together.
- R7: Only the losing port sees busy low. The winner's busy stays high, and grant_l/grant_r is 1 for the winner only. The two grants are never both 1.
- R8: A grant holds for as long as the contention persists. Once the contention ends, the loser's busy flag returns high after the next edge.
- R9: If the winner leaves while the loser stays selected at the address, the loser wins when the former winner returns.
- R10: While reset is asserted (rst_n low), both busy flags are high and both grants are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_l_n | input | 1 | Left port select, active low |
| addr_l | input | 10 | Left port address |
| sel_r_n | input | 1 | Right port select, active low |
| addr_r | input | 10 | Right port address |
| busy_l_n | output | 1 | Left port must wait, active low |
| busy_r_n | output | 1 | Right port must wait, active low |
| grant_l | output | 1 | Left port owns the contended location |
| grant_r | output | 1 | Right port owns the contended location |

## Verification
Two functions can land in the same edge: a winner ends its contention, and the arbiter immediately has to choose a new winner. The bench provokes this by making the winner deselect for one cycle and return while the loser keeps waiting. It then checks that the release and the reversal of the grant appear on consecutive cycles. A second collision pits a new contention against the tie rule. Both ports move their addresses onto the same location in one cycle, and the bench checks that exactly one busy flag falls and that it is the right one.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;
endpackage

// File: rtl/arb_match.sv
// Decodes port activity and detects a same-location collision.
module arb_match #(
  parameter int unsigned AW = 10
) (
  input  logic          sel_l_n,
  input  logic          sel_r_n,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  output logic          act_l,
  output logic          act_r,
  output logic          clash
);
  logic same_loc;

  assign act_l    = ~sel_l_n;
  assign act_r    = ~sel_r_n;
  assign same_loc = (addr_l == addr_r);
  assign clash    = act_l & act_r & same_loc;
endmodule

// File: rtl/arb_order.sv
// Remembers each port's previous access and flags ports that were already
// sitting at their current location one cycle earlier.
module arb_order #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_l,
  input  logic          act_r,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  output logic          held_l,
  output logic          held_r
);
  import arb_pkg::*;

  logic [NUM_PORTS-1:0] act_v;
  logic [NUM_PORTS-1:0] held_v;
  logic [AW-1:0]        addr_v [NUM_PORTS];

  assign act_v[PORT_L]  = act_l;
  assign act_v[PORT_R]  = act_r;
  assign addr_v[PORT_L] = addr_l;
  assign addr_v[PORT_R] = addr_r;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic          prev_act;
    logic [AW-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_act  <= 1'b0;
        prev_addr <= '0;
      end else begin
        prev_act  <= act_v[p];
        prev_addr <= addr_v[p];
      end
    end

    assign held_v[p] = act_v[p] & prev_act & (prev_addr == addr_v[p]);
  end

  assign held_l = held_v[PORT_L];
  assign held_r = held_v[PORT_R];
endmodule

// File: rtl/arb_grant.sv
// Ownership state and registered busy/grant flags.
module arb_grant #(
  parameter bit TIE_LEFT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clash,
  input  logic held_l,
  input  logic held_r,
  output logic busy_l_n,
  output logic busy_r_n,
  output logic grant_l,
  output logic grant_r
);
  import arb_pkg::*;

  localparam owner_e TIE_OWNER = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;

  owner_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    if (!clash) begin
      own_d = OWN_NONE;
    end else if (own_q == OWN_NONE) begin
      if (held_l && !held_r)      own_d = OWN_LEFT;
      else if (held_r && !held_l) own_d = OWN_RIGHT;
      else                        own_d = TIE_OWNER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= OWN_NONE;
      busy_l_n <= 1'b1;
      busy_r_n <= 1'b1;
      grant_l  <= 1'b0;
      grant_r  <= 1'b0;
    end else begin
      own_q    <= own_d;
      busy_l_n <= (own_d != OWN_RIGHT);
      busy_r_n <= (own_d != OWN_LEFT);
      grant_l  <= (own_d == OWN_LEFT);
      grant_r  <= (own_d == OWN_RIGHT);
    end
  end

  // R6: never both ports held off
  p_one_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l_n || busy_r_n));

  // R7: a low busy always pairs with the other side's grant
  p_loser_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_r_n |-> (grant_l && busy_l_n && !grant_r)));

  // R8: a grant persists while the collision persists
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_l && clash) |=> grant_l));

  // R3: earlier left arrival wins a fresh collision
  p_left_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clash && !grant_l && !grant_r && held_l && !held_r) |=> !busy_r_n));

  // R4: earlier right arrival wins a fresh collision
  p_right_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clash && !grant_l && !grant_r && held_r && !held_l) |=> !busy_l_n));
endmodule

// File: rtl/dpram_contend_arb.sv
module dpram_contend_arb #(
  parameter int unsigned ADDR_W   = 10,
  parameter bit          TIE_LEFT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_l_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              sel_r_n,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              grant_l,
  output logic              grant_r
);
  logic act_l, act_r, clash;
  logic held_l, held_r;

  arb_match #(.AW(ADDR_W)) u_match (
    .sel_l_n (sel_l_n),
    .sel_r_n (sel_r_n),
    .addr_l  (addr_l),
    .addr_r  (addr_r),
    .act_l   (act_l),
    .act_r   (act_r),
    .clash   (clash)
  );

  arb_order #(.AW(ADDR_W)) u_order (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_l  (act_l),
    .act_r  (act_r),
    .addr_l (addr_l),
    .addr_r (addr_r),
    .held_l (held_l),
    .held_r (held_r)
  );

  arb_grant #(.TIE_LEFT(TIE_LEFT)) u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .clash    (clash),
    .held_l   (held_l),
    .held_r   (held_r),
    .busy_l_n (busy_l_n),
    .busy_r_n (busy_r_n),
    .grant_l  (grant_l),
    .grant_r  (grant_r)
  );

  // R1: an edge without a collision leaves both ports free
  p_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(!sel_l_n && !sel_r_n && addr_l == addr_r)
       |=> (busy_l_n && busy_r_n && !grant_l && !grant_r)));

  // R7: grants are mutually exclusive
  p_grant_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(grant_l && grant_r)));
endmodule

// File: tb/sim_dpram_contend_arb.sv
`timescale 1ns/1ps
module sim_dpram_contend_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_l_n = 1'b1, sel_r_n = 1'b1;
  logic [9:0] addr_l = '0, addr_r = '0;
  logic       busy_l_n, busy_r_n, grant_l, grant_r;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic  bl, br, gl, gr;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  dpram_contend_arb u0 (
    .clk(clk), .rst_n(rst_n),
    .sel_l_n(sel_l_n), .addr_l(addr_l),
    .sel_r_n(sel_r_n), .addr_r(addr_r),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .grant_l(grant_l), .grant_r(grant_r)
  );

  function automatic void compare(input exp_t e);
    checks++;
    if (busy_l_n !== e.bl || busy_r_n !== e.br || grant_l !== e.gl || grant_r !== e.gr) begin
      errors++;
      $display("FAIL %s: got bl=%b br=%b gl=%b gr=%b, expected bl=%b br=%b gl=%b gr=%b",
               e.tag, busy_l_n, busy_r_n, grant_l, grant_r, e.bl, e.br, e.gl, e.gr);
    end
  endfunction

  // driver: apply inputs at the falling edge, push what the next edge must show
  task automatic step(input logic sl, input logic [9:0] al, input logic sr,
                      input logic [9:0] ar, input logic ebl, input logic ebr,
                      input logic egl, input logic egr, input string tag);
    exp_t e;
    @(negedge clk);
    sel_l_n = sl; addr_l = al; sel_r_n = sr; addr_r = ar;
    e.bl = ebl; e.br = ebr; e.gl = egl; e.gr = egr; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: sample a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && sb.size() > 0) compare(sb.pop_front());
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        checks++; errors++;
        $display("FAIL watchdog: got run still active, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    exp_t r;
    // R10: reset state with both ports colliding
    sel_l_n = 1'b0; sel_r_n = 1'b0; addr_l = 10'd4; addr_r = 10'd4;
    repeat (3) @(posedge clk);
    #5;
    r.bl = 1; r.br = 1; r.gl = 0; r.gr = 0; r.tag = "R10 reset";
    compare(r);
    @(negedge clk);
    sel_l_n = 1'b1; sel_r_n = 1'b1;
    rst_n = 1'b1;

    // R1: no contention cases
    step(1, 10'd5, 1, 10'd5, 1, 1, 0, 0, "R1 both deselected");
    step(0, 10'd5, 1, 10'd5, 1, 1, 0, 0, "R1 right deselected");
    step(0, 10'd5, 0, 10'd6, 1, 1, 0, 0, "R1 addresses differ");
    // R3/R2: right moves onto left's location
    step(0, 10'd5, 0, 10'd5, 1, 0, 1, 0, "R3 left address first");
    step(0, 10'd5, 0, 10'd5, 1, 0, 1, 0, "R8 grant held");
    step(0, 10'd5, 0, 10'd5, 1, 0, 1, 0, "R7 winner busy stays high");
    // R8: winner moves away -> release
    step(0, 10'd7, 0, 10'd5, 1, 1, 0, 0, "R8 release on address change");
    // R4: left moves onto right's location
    step(0, 10'd5, 0, 10'd5, 0, 1, 0, 1, "R4 right address first");
    step(1, 10'd5, 1, 10'd5, 1, 1, 0, 0, "R8 release on deselect");
    // R5: select order, left earlier
    step(0, 10'd9, 1, 10'd9, 1, 1, 0, 0, "R5 left alone");
    step(0, 10'd9, 0, 10'd9, 1, 0, 1, 0, "R5 left select first");
    step(1, 10'd9, 1, 10'd9, 1, 1, 0, 0, "R1 idle");
    // R5: right earlier
    step(1, 10'd9, 0, 10'd9, 1, 1, 0, 0, "R5 right alone");
    step(0, 10'd9, 0, 10'd9, 0, 1, 0, 1, "R5 right select first");
    step(1, 10'd9, 1, 10'd9, 1, 1, 0, 0, "R1 idle");
    // R6: simultaneous selects
    step(0, 10'h3FF, 0, 10'h3FF, 1, 0, 1, 0, "R6 simultaneous select");
    // R9: winner leaves for one cycle, loser waits, winner returns
    step(1, 10'h3FF, 0, 10'h3FF, 1, 1, 0, 0, "R9 winner leaves");
    step(0, 10'h3FF, 0, 10'h3FF, 0, 1, 0, 1, "R9 waiting loser takes over");
    // R6: simultaneous address arrival
    step(0, 10'd1, 0, 10'd2, 1, 1, 0, 0, "R1 separate addresses");
    step(0, 10'd3, 0, 10'd3, 1, 0, 1, 0, "R6 simultaneous address");
    // R8: loser leaves -> release
    step(0, 10'd3, 1, 10'd3, 1, 1, 0, 0, "R8 loser leaves");
    step(1, 10'd0, 1, 10'd0, 1, 1, 0, 0, "R1 final idle");

    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule